// File: doc/BRIEF.md
# Multiprocessor Instruction/Data Cache Synchronizer

This controller makes freshly written code safe to execute on a machine where every processor has separate instruction and data caches, and where no instruction cache watches data-side writes. A processor that has just stored instructions as data raises a request carrying a line range. The range is a first line address and a number of lines.

The controller first orders every data cache in the system to write that range back to memory. Only once every data cache has confirmed does it order every instruction cache to drop its valid bits for the same range. Instruction caches hold no dirty lines, so they are only ever invalidated. While the operation runs, a global refill-inhibit output keeps all instruction caches from fetching stale lines. The requesting processor stays stalled until every cache has confirmed.

Requests from several processors may arrive together. They are served one at a time in round-robin order, and the others wait. Each cache takes part only through a request/acknowledge pair per phase.

Top module: `icsync_top`

## Requirements
- R1: When several processors request at once, the grant goes to the first requester found scanning upward (wrapping) from the processor served last. After reset the scan starts at processor 0.
- R2: Only one operation runs at a time. A request that is not granted stays pending, with its stall held, until it is served. While an operation is in progress the broadcast range does not change.
- R3: Two clock edges after a request with a nonzero count is granted, `wbReq` is all ones. At that point `cmdStart` and `cmdCount` carry the granted processor's start line and line count.
- R4: Each `wbReq[i]` and `invReq[i]` bit stays high until the edge at which its matching acknowledge is sampled high, and it falls at that edge.
- R5: No `invReq` bit is raised while any `wbReq` bit is still high. `invReq` goes to all ones one cycle after the last data-cache acknowledge has been recorded.
- R6: `refillInhibit` is high in every cycle in which any `wbReq` or `invReq` bit is high. It stays high from the first cycle after the grant to the end of the invalidate phase, and it is low when idle.
- R7: `doneOut` is a one-cycle pulse on the requester's bit only. In that cycle `cpuStall` for the requester goes low. `cpuStall[i]` is otherwise high whenever `reqValid[i]` is high.
- R8: A request with a line count of zero raises `doneOut` one edge after the grant. It raises no `wbReq` or `invReq` bit and leaves `refillInhibit` low.
- R9: After reset, `wbReq`, `invReq`, `doneOut` and `refillInhibit` are all zero.
- R10: An acknowledge on a processor whose request bit for that phase is low has no effect. A stray `invAck` during the writeback phase does not shorten the invalidate phase, so `invReq` still goes to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | NUM_CPU | Per-processor request, held until its done pulse |
| reqStart | input | NUM_CPU*LINE_W | Start line address per processor, packed by processor index |
| reqCount | input | NUM_CPU*CNT_W | Line count per processor, packed by processor index |
| cpuStall | output | NUM_CPU | Stall to each requesting processor |
| doneOut | output | NUM_CPU | One-cycle completion pulse to the requester |
| refillInhibit | output | 1 | Global block on instruction-cache refills |
| cmdStart | output | LINE_W | Broadcast start line of the active operation |
| cmdCount | output | CNT_W | Broadcast line count of the active operation |
| wbReq | output | NUM_CPU | Writeback command to each data cache |
| wbAck | input | NUM_CPU | Writeback completion from each data cache |
| invReq | output | NUM_CPU | Invalidate command to each instruction cache |
| invAck | input | NUM_CPU | Invalidate completion from each instruction cache |

## Verification
Several properties hold on every cycle and are checked that way: no invalidate command coexists with an outstanding writeback, a command bit falls only on its acknowledge, the inhibit covers every command, done never lasts two cycles, and at most one grant is active. Other behaviour shows only in the bench's directed scenarios. These are the round-robin order of a three-way collision, the exact cycle the range reaches the caches, the shortcut for a zero count, and the disregard of stray acknowledges. The bench checks them against completion order and the broadcast range.

// File: rtl/icsync_pkg.sv
package icsync_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WB_ISSUE  = 3'd1,
    ST_WB_WAIT   = 3'd2,
    ST_INV_ISSUE = 3'd3,
    ST_INV_WAIT  = 3'd4,
    ST_DONE      = 3'd5
  } syncState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grantLoad;
    logic wbLaunch;
    logic invLaunch;
  } ctrlStrobe_t;

endpackage

// File: rtl/icsync_rr_arb.sv
module icsync_rr_arb #(
  parameter int NUM_CPU = 4,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] reqVec,
  input  logic               advance,
  output logic               anyReq,
  output logic [IDX_W-1:0]   grantIdx,
  output logic [NUM_CPU-1:0] grantOh
);

  logic [IDX_W-1:0] lastIdx;
  logic             found;
  int               cand;

  always_comb begin
    found    = 1'b0;
    grantIdx = '0;
    cand     = 0;
    for (int k = 1; k <= NUM_CPU; k++) begin
      cand = (int'(lastIdx) + k) % NUM_CPU;
      if (!found && reqVec[cand]) begin
        found    = 1'b1;
        grantIdx = IDX_W'(cand);
      end
    end
    anyReq  = found;
    grantOh = found ? (NUM_CPU'(1) << grantIdx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lastIdx <= IDX_W'(NUM_CPU - 1);
    else if (advance && found) lastIdx <= grantIdx;
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantOh));

  // R1
  grant_is_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grantOh & ~reqVec) == '0));

endmodule

// File: rtl/icsync_datapath.sv
module icsync_datapath
  import icsync_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int LINE_W  = 26,
  parameter int CNT_W   = 12,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrobe_t               strobe,
  input  logic [NUM_CPU-1:0]        reqValid,
  input  logic [NUM_CPU*LINE_W-1:0] reqStart,
  input  logic [NUM_CPU*CNT_W-1:0]  reqCount,
  input  logic [NUM_CPU-1:0]        wbAck,
  input  logic [NUM_CPU-1:0]        invAck,
  output logic                      anyReq,
  output logic                      zeroCount,
  output logic                      wbAllDone,
  output logic                      invAllDone,
  output logic [IDX_W-1:0]          ownerIdx,
  output logic [LINE_W-1:0]         cmdStart,
  output logic [CNT_W-1:0]          cmdCount,
  output logic [NUM_CPU-1:0]        wbReq,
  output logic [NUM_CPU-1:0]        invReq
);

  logic [IDX_W-1:0]   grantIdx;
  logic [NUM_CPU-1:0] grantOh;
  logic [NUM_CPU-1:0] wbDoneQ, invDoneQ;

  icsync_rr_arb #(.NUM_CPU(NUM_CPU)) uArb (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqVec  (reqValid),
    .advance (strobe.grantLoad),
    .anyReq  (anyReq),
    .grantIdx(grantIdx),
    .grantOh (grantOh)
  );

  assign zeroCount = (reqCount[grantIdx*CNT_W +: CNT_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ownerIdx <= '0;
      cmdStart <= '0;
      cmdCount <= '0;
    end else if (strobe.grantLoad) begin
      ownerIdx <= grantIdx;
      cmdStart <= reqStart[grantIdx*LINE_W +: LINE_W];
      cmdCount <= reqCount[grantIdx*CNT_W +: CNT_W];
    end
  end

  // acknowledge collection, one bit per processor and phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbReq    <= '0;
      wbDoneQ  <= '0;
      invReq   <= '0;
      invDoneQ <= '0;
    end else begin
      for (int i = 0; i < NUM_CPU; i++) begin
        if (strobe.wbLaunch) begin
          wbReq[i]   <= 1'b1;
          wbDoneQ[i] <= 1'b0;
        end else if (wbReq[i] && wbAck[i]) begin
          wbReq[i]   <= 1'b0;
          wbDoneQ[i] <= 1'b1;
        end
        if (strobe.invLaunch) begin
          invReq[i]   <= 1'b1;
          invDoneQ[i] <= 1'b0;
        end else if (invReq[i] && invAck[i]) begin
          invReq[i]   <= 1'b0;
          invDoneQ[i] <= 1'b1;
        end
      end
    end
  end

  assign wbAllDone  = &wbDoneQ;
  assign invAllDone = &invDoneQ;

  // R5
  inv_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|invReq) |-> (wbReq == '0));

  // R2
  range_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbReq != '0 || invReq != '0) |=> $stable(cmdStart));

  for (genvar g = 0; g < NUM_CPU; g++) begin : gHold
    // R4
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wbReq[g] && !wbAck[g]) |=> wbReq[g]);
    // R4
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (invReq[g] && !invAck[g]) |=> invReq[g]);
  end

endmodule

// File: rtl/icsync_ctrl.sv
module icsync_ctrl
  import icsync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        anyReq,
  input  logic        zeroCount,
  input  logic        wbAllDone,
  input  logic        invAllDone,
  output ctrlStrobe_t strobe,
  output logic        inhibit,
  output logic        finishing
);

  syncState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (anyReq) begin
        strobe.grantLoad = 1'b1;
        stateNext = zeroCount ? ST_DONE : ST_WB_ISSUE;
      end
      ST_WB_ISSUE: begin
        strobe.wbLaunch = 1'b1;
        stateNext = ST_WB_WAIT;
      end
      ST_WB_WAIT:   if (wbAllDone) stateNext = ST_INV_ISSUE;
      ST_INV_ISSUE: begin
        strobe.invLaunch = 1'b1;
        stateNext = ST_INV_WAIT;
      end
      ST_INV_WAIT:  if (invAllDone) stateNext = ST_DONE;
      ST_DONE:      stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign inhibit   = (state == ST_WB_ISSUE) || (state == ST_WB_WAIT) ||
                     (state == ST_INV_ISSUE) || (state == ST_INV_WAIT);
  assign finishing = (state == ST_DONE);

  // R7
  done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/icsync_top.sv
module icsync_top
  import icsync_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int LINE_W  = 26,
  parameter int CNT_W   = 12,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CPU-1:0]        reqValid,
  input  logic [NUM_CPU*LINE_W-1:0] reqStart,
  input  logic [NUM_CPU*CNT_W-1:0]  reqCount,
  output logic [NUM_CPU-1:0]        cpuStall,
  output logic [NUM_CPU-1:0]        doneOut,
  output logic                      refillInhibit,
  output logic [LINE_W-1:0]         cmdStart,
  output logic [CNT_W-1:0]          cmdCount,
  output logic [NUM_CPU-1:0]        wbReq,
  input  logic [NUM_CPU-1:0]        wbAck,
  output logic [NUM_CPU-1:0]        invReq,
  input  logic [NUM_CPU-1:0]        invAck
);

  ctrlStrobe_t      strobe;
  logic             anyReq, zeroCount, wbAllDone, invAllDone, finishing;
  logic [IDX_W-1:0] ownerIdx;

  icsync_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .anyReq    (anyReq),
    .zeroCount (zeroCount),
    .wbAllDone (wbAllDone),
    .invAllDone(invAllDone),
    .strobe    (strobe),
    .inhibit   (refillInhibit),
    .finishing (finishing)
  );

  icsync_datapath #(.NUM_CPU(NUM_CPU), .LINE_W(LINE_W), .CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .reqValid  (reqValid),
    .reqStart  (reqStart),
    .reqCount  (reqCount),
    .wbAck     (wbAck),
    .invAck    (invAck),
    .anyReq    (anyReq),
    .zeroCount (zeroCount),
    .wbAllDone (wbAllDone),
    .invAllDone(invAllDone),
    .ownerIdx  (ownerIdx),
    .cmdStart  (cmdStart),
    .cmdCount  (cmdCount),
    .wbReq     (wbReq),
    .invReq    (invReq)
  );

  assign doneOut  = finishing ? (NUM_CPU'(1) << ownerIdx) : '0;
  assign cpuStall = reqValid & ~doneOut;

  // R6
  inhibit_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbReq != '0 || invReq != '0) |-> refillInhibit);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut != '0) |=> (doneOut == '0));

  // R7
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(doneOut));

endmodule

// File: tb/tb_icsync_top.sv
module tb_icsync_top;

  localparam int N  = 4;
  localparam int LW = 26;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  reqValid = '0;
  logic [N*LW-1:0] reqStart = '0;
  logic [N*CW-1:0] reqCount = '0;
  logic [N-1:0]  cpuStall, doneOut, wbReq, invReq;
  logic          refillInhibit;
  logic [LW-1:0] cmdStart;
  logic [CW-1:0] cmdCount;
  logic [N-1:0]  wbAckR = '0, invAckR = '0, strayInv = '0;
  logic [N-1:0]  wbAck, invAck;

  assign wbAck  = wbAckR;
  assign invAck = invAckR | strayInv;

  always #10 clk = ~clk;

  icsync_top #(.NUM_CPU(N), .LINE_W(LW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqStart(reqStart),
    .reqCount(reqCount), .cpuStall(cpuStall), .doneOut(doneOut),
    .refillInhibit(refillInhibit), .cmdStart(cmdStart), .cmdCount(cmdCount),
    .wbReq(wbReq), .wbAck(wbAck), .invReq(invReq), .invAck(invAck));

  int testsRun = 0, testsFailed = 0;
  int wbDly[N], invDly[N], wbCnt[N], invCnt[N];
  int orderViol = 0, dropViol = 0, inhibViol = 0, doneViol = 0;
  int doneLog[8];
  logic [LW-1:0] startLog[8];
  int doneN = 0;
  logic [N-1:0] prevWbReq = '0, prevInvReq = '0;
  logic [N-1:0] prevDone = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cache responders, requester release and per-cycle monitors
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (prevWbReq[i] && !wbReq[i] && !wbAckR[i]) dropViol++;
        if (prevInvReq[i] && !invReq[i] && !invAck[i]) dropViol++;
      end
      if (invReq != '0 && wbReq != '0) orderViol++;
      if ((wbReq != '0 || invReq != '0) && !refillInhibit) inhibViol++;
      if (prevDone != '0 && doneOut != '0) doneViol++;
      if ((doneOut & ~reqValid) != '0) doneViol++;
      if (doneOut != '0) begin
        for (int i = 0; i < N; i++)
          if (doneOut[i] && doneN < 8) begin
            doneLog[doneN] = i;
            startLog[doneN] = cmdStart;
            doneN++;
          end
        reqValid = reqValid & ~doneOut;
      end
      for (int i = 0; i < N; i++) begin
        if (wbAckR[i]) wbAckR[i] = 1'b0;
        else if (wbReq[i]) begin
          if (wbCnt[i] >= wbDly[i]) begin wbAckR[i] = 1'b1; wbCnt[i] = 0; end
          else wbCnt[i]++;
        end
        if (invAckR[i]) invAckR[i] = 1'b0;
        else if (invReq[i]) begin
          if (invCnt[i] >= invDly[i]) begin invAckR[i] = 1'b1; invCnt[i] = 0; end
          else invCnt[i]++;
        end
      end
      prevWbReq  = wbReq;
      prevInvReq = invReq;
      prevDone   = doneOut;
    end
  end

  task automatic setReq(input int cpu, input int start, input int count);
    reqStart[cpu*LW +: LW] = LW'(start);
    reqCount[cpu*CW +: CW] = CW'(count);
    reqValid[cpu] = 1'b1;
  endtask

  task automatic waitIdleReqs();
    int guard = 0;
    while (reqValid != '0 && guard < 2000) begin @(negedge clk); guard++; end
    check(reqValid == '0, "R2", "all pending requests served", reqValid, 0);
  endtask

  task automatic testReset();
    check(wbReq == '0, "R9", "wbReq after reset", wbReq, 0);
    check(invReq == '0, "R9", "invReq after reset", invReq, 0);
    check(doneOut == '0, "R9", "doneOut after reset", doneOut, 0);
    check(refillInhibit == 1'b0, "R9", "inhibit after reset", refillInhibit, 0);
  endtask

  task automatic testSingle();
    wbDly  = '{1, 3, 2, 5};
    invDly = '{2, 1, 4, 1};
    setReq(1, 'h100, 8);
    @(negedge clk);
    check(refillInhibit == 1'b1, "R6", "inhibit after grant", refillInhibit, 1);
    @(negedge clk);
    check(wbReq == 4'hF, "R3", "writeback to all caches", wbReq, 'hF);
    check(cmdStart == LW'('h100), "R3", "broadcast start", cmdStart, 'h100);
    check(cmdCount == CW'(8), "R3", "broadcast count", cmdCount, 8);
    check(invReq == '0, "R5", "no invalidate during writeback", invReq, 0);
    check(cpuStall[1] == 1'b1, "R7", "requester stalled", cpuStall[1], 1);
    waitIdleReqs();
    check(doneN == 1 && doneLog[0] == 1, "R7", "done on requester only",
          doneLog[0], 1);
    @(negedge clk);
    check(refillInhibit == 1'b0, "R6", "inhibit released", refillInhibit, 0);
    check(cpuStall == '0, "R7", "stall released", cpuStall, 0);
  endtask

  task automatic testRoundRobin();
    wbDly  = '{0, 2, 1, 3};
    invDly = '{1, 0, 2, 0};
    doneN = 0;
    setReq(0, 'h200, 4);
    setReq(2, 'h202, 4);
    setReq(3, 'h203, 4);
    @(negedge clk);
    @(negedge clk);
    check(cpuStall[0] && cpuStall[3], "R2", "pending requesters stalled",
          cpuStall, 'h9);
    waitIdleReqs();
    check(doneLog[0] == 2, "R1", "first served after cpu1", doneLog[0], 2);
    check(doneLog[1] == 3, "R1", "second served", doneLog[1], 3);
    check(doneLog[2] == 0, "R1", "wrap to cpu0", doneLog[2], 0);
    check(startLog[0] == LW'('h202) && startLog[1] == LW'('h203) &&
          startLog[2] == LW'('h200), "R2", "range follows each owner",
          startLog[2], 'h200);
  endtask

  task automatic testZeroCount();
    doneN = 0;
    setReq(3, 'h300, 0);
    @(negedge clk);
    check(doneOut == 4'b1000, "R8", "zero count done at once", doneOut, 'h8);
    check(wbReq == '0 && invReq == '0, "R8", "no cache commands", wbReq, 0);
    check(refillInhibit == 1'b0, "R8", "no inhibit", refillInhibit, 0);
    @(negedge clk);
    check(doneOut == '0, "R7", "done lasts one cycle", doneOut, 0);
  endtask

  task automatic testStrayAck();
    int guard = 0;
    wbDly  = '{6, 6, 6, 6};
    invDly = '{3, 3, 3, 3};
    setReq(0, 'h400, 2);
    repeat (4) @(negedge clk);
    strayInv = 4'hF;
    @(negedge clk);
    strayInv = '0;
    while (invReq == '0 && guard < 200) begin @(negedge clk); guard++; end
    check(invReq == 4'hF, "R10", "stray invAck ignored", invReq, 'hF);
    @(negedge clk);
    check(invReq == 4'hF && doneOut == '0, "R10", "invalidate phase not cut",
          invReq, 'hF);
    waitIdleReqs();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      wbDly[i] = 1; invDly[i] = 1; wbCnt[i] = 0; invCnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testSingle();
    testRoundRobin();
    testZeroCount();
    testStrayAck();
    repeat (3) @(negedge clk);
    check(orderViol == 0, "R5", "invalidate never overlaps writeback", orderViol, 0);
    check(dropViol == 0, "R4", "command held until acknowledged", dropViol, 0);
    check(inhibViol == 0, "R6", "inhibit covers all commands", inhibViol, 0);
    check(doneViol == 0, "R7", "done single pulse to requester", doneViol, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule